// File: doc/BRIEF.md
# Two-Level Interrupt Pending Controller

This block gathers interrupt requests from a set of primary sources and from a bank of secondary sources arranged in fixed-size groups. Each group of secondaries feeds one primary bit. A request is first held in a pending register. Masking then decides which pending requests take part in arbitration. A fixed-priority arbiter loads exactly one winner into a one-hot in-service register. The bit index of that winner is reported in an index register, and a single `irq` line tells the processor that something is in service.

Software works through a flat register bus with a write strobe, a 3-bit address and combinational read data. The handler reads the index register and clears the serviced request by writing ones. It clears the secondary pending bit first (if any), then the primary pending bit, then the in-service bit. Once both the primary pending bit and the in-service bit of the serviced request are gone, the index register reads zero again.

Top module: `irq_ctrl_2lvl`

## Requirements
- R1: After reset, the primary pending register (address 0), the secondary pending register (address 4), the in-service register (address 2) and the index register (address 3) read zero, and `irq` is low. The primary mask (address 1) and the secondary mask (address 5) read all ones across their implemented bits.
- R2: A primary input `src_req[i]` that is high at a clock edge sets bit i of the primary pending register at that edge, whether or not bit i is masked.
- R3: Writing the primary pending, secondary pending or in-service register clears each bit written as 1. Bits written as 0 keep their value.
- R4: When hardware sets a pending bit in the same cycle that software clears it, the bit stays set.
- R5: `sub_req[j]` sets bit j of the secondary pending register. While that bit is pending and bit j of the secondary mask is 0, it sets primary pending bit `SUB_BASE + j / SUB_PER_GRP`. A masked secondary sets nothing at the primary level.
- R6: A primary pending bit whose primary mask bit is 1 never enters the in-service register.
- R7: When the in-service register is zero, the next edge loads it with the lowest-index bit among the pending, unmasked primary requests. While it is nonzero it changes only through software clears, so at most one bit is ever set.
- R8: While a bit is set in the in-service register, the index register holds that bit's position.
- R9: The index register returns to 0 at the edge where both the in-service bit and the primary pending bit of the serviced request are clear. It keeps its value while only one of the two has been cleared.
- R10: `irq` is high exactly when the in-service register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Primary request lines, sampled each edge |
| sub_req | input | NUM_SUB | Secondary request lines, sampled each edge |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with 16 primary sources and 6 secondaries in groups of three, routed to primary bits 10 and 11. With these values the whole register width is easy to see and to write in directed tests. Both groups can be driven at once. Requests on either side of the group bits can be set up to show the lowest-index win and the hold while the in-service register is busy. The reduced width also makes the all-ones mask reset value, and the same-cycle set/clear collision, easy to observe at the ports.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    RA_SRC_PEND  = 3'd0,
    RA_PRIM_MASK = 3'd1,
    RA_SERVICE   = 3'd2,
    RA_INDEX     = 3'd3,
    RA_SUB_PEND  = 3'd4,
    RA_SUB_MASK  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/ic_sub_stage.sv
module ic_sub_stage #(
  parameter int NUM_SUB     = 15,
  parameter int SUB_PER_GRP = 3,
  localparam int NUM_GRP    = NUM_SUB / SUB_PER_GRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SUB-1:0] sub_req,
  input  logic               clr_en,
  input  logic [NUM_SUB-1:0] clr_bits,
  input  logic [NUM_SUB-1:0] sub_mask,
  output logic [NUM_SUB-1:0] pend_q,
  output logic [NUM_GRP-1:0] grp_act
);
  logic [NUM_SUB-1:0] pend_d;
  logic [NUM_SUB-1:0] live;

  // hardware set wins over a same-cycle software clear
  always_comb begin
    pend_d = sub_req | (pend_q & ~(clr_en ? clr_bits : '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign live = pend_q & ~sub_mask;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_act[g] = |live[g*SUB_PER_GRP +: SUB_PER_GRP];
  end
endmodule

// File: rtl/ic_src_stage.sv
module ic_src_stage #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_bits,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] pend_d
);
  always_comb begin
    pend_d = set_bits | (pend_q & ~(clr_en ? clr_bits : '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
  parameter int NUM_SRC = 32,
  localparam int OFF_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               any,
  output logic [OFF_W-1:0]   idx,
  output logic [NUM_SRC-1:0] onehot
);
  // scan from the top so the lowest set index is left in idx
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = OFF_W'(i);
    end
  end

  assign any    = |cand;
  assign onehot = any ? (NUM_SRC'(1) << idx) : '0;
endmodule

// File: rtl/irq_ctrl_2lvl.sv
module irq_ctrl_2lvl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int NUM_SUB     = 15,
  parameter int SUB_PER_GRP = 3,
  parameter int SUB_BASE    = 23,
  localparam int NUM_GRP    = NUM_SUB / SUB_PER_GRP,
  localparam int OFF_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_req,
  input  logic [NUM_SUB-1:0]  sub_req,
  input  logic                bus_we,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [REG_DW-1:0]   bus_wdata,
  output logic [REG_DW-1:0]   bus_rdata,
  output logic                irq
);
  // write decode
  logic wr_src, wr_pmask, wr_serv, wr_sub, wr_smask;
  assign wr_src   = bus_we && (bus_addr == RA_SRC_PEND);
  assign wr_pmask = bus_we && (bus_addr == RA_PRIM_MASK);
  assign wr_serv  = bus_we && (bus_addr == RA_SERVICE);
  assign wr_sub   = bus_we && (bus_addr == RA_SUB_PEND);
  assign wr_smask = bus_we && (bus_addr == RA_SUB_MASK);

  // mask registers
  logic [NUM_SRC-1:0] prim_mask_q, prim_mask_d;
  logic [NUM_SUB-1:0] sub_mask_q, sub_mask_d;

  always_comb begin
    prim_mask_d = wr_pmask ? bus_wdata[NUM_SRC-1:0] : prim_mask_q;
    sub_mask_d  = wr_smask ? bus_wdata[NUM_SUB-1:0] : sub_mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_mask_q <= '1;
      sub_mask_q  <= '1;
    end else begin
      prim_mask_q <= prim_mask_d;
      sub_mask_q  <= sub_mask_d;
    end
  end

  // secondary level
  logic [NUM_SUB-1:0] sub_pend_q;
  logic [NUM_GRP-1:0] grp_act;

  ic_sub_stage #(.NUM_SUB(NUM_SUB), .SUB_PER_GRP(SUB_PER_GRP)) u_sub (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_req  (sub_req),
    .clr_en   (wr_sub),
    .clr_bits (bus_wdata[NUM_SUB-1:0]),
    .sub_mask (sub_mask_q),
    .pend_q   (sub_pend_q),
    .grp_act  (grp_act)
  );

  // route each group onto its primary bit
  logic [NUM_SRC-1:0] grp_vec;
  always_comb begin
    grp_vec = '0;
    for (int g = 0; g < NUM_GRP; g++) grp_vec[SUB_BASE + g] = grp_act[g];
  end

  // primary level
  logic [NUM_SRC-1:0] src_pend_q, src_pend_d;

  ic_src_stage #(.NUM_SRC(NUM_SRC)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (src_req | grp_vec),
    .clr_en   (wr_src),
    .clr_bits (bus_wdata[NUM_SRC-1:0]),
    .pend_q   (src_pend_q),
    .pend_d   (src_pend_d)
  );

  // arbitration
  logic [NUM_SRC-1:0] cand, win_onehot;
  logic [OFF_W-1:0]   win_idx;
  logic               win_any;

  assign cand = src_pend_q & ~prim_mask_q;

  ic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .cand   (cand),
    .any    (win_any),
    .idx    (win_idx),
    .onehot (win_onehot)
  );

  // in-service and index registers
  logic [NUM_SRC-1:0] serv_q, serv_d;
  logic [OFF_W-1:0]   offset_q, offset_d;
  logic               serv_empty, latch_en;

  assign serv_empty = (serv_q == '0);
  assign latch_en   = serv_empty && win_any;

  always_comb begin
    if (serv_empty) serv_d = latch_en ? win_onehot : '0;
    else            serv_d = serv_q & ~(wr_serv ? bus_wdata[NUM_SRC-1:0] : '0);
  end

  always_comb begin
    if (latch_en)                                          offset_d = win_idx;
    else if ((serv_d == '0) && !src_pend_d[offset_q])      offset_d = '0;
    else                                                   offset_d = offset_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serv_q   <= '0;
      offset_q <= '0;
    end else begin
      serv_q   <= serv_d;
      offset_q <= offset_d;
    end
  end

  assign irq = !serv_empty;

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_SRC_PEND:  bus_rdata[NUM_SRC-1:0] = src_pend_q;
      RA_PRIM_MASK: bus_rdata[NUM_SRC-1:0] = prim_mask_q;
      RA_SERVICE:   bus_rdata[NUM_SRC-1:0] = serv_q;
      RA_INDEX:     bus_rdata[OFF_W-1:0]   = offset_q;
      RA_SUB_PEND:  bus_rdata[NUM_SUB-1:0] = sub_pend_q;
      RA_SUB_MASK:  bus_rdata[NUM_SUB-1:0] = sub_mask_q;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 32,
  parameter int OFF_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic [NUM_SRC-1:0] src_pend,
  input logic [NUM_SRC-1:0] prim_mask,
  input logic [NUM_SRC-1:0] serv,
  input logic [NUM_SRC-1:0] cand,
  input logic [OFF_W-1:0]   offset,
  input logic               bus_we
);
  logic up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  AST_ONE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(serv)); // R7

  AST_INDEX_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (serv != '0) |-> serv[offset]); // R8

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> ((src_pend & $past(src_req)) == $past(src_req))); // R4

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(serv != '0) && !$past(bus_we)) |-> $stable(serv)); // R7

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(serv == '0) && (serv != '0)) |->
      (((serv & $past(cand)) != '0) && (((serv - 1'b1) & $past(cand)) == '0))); // R7

  AST_MASKED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(serv == '0)) |-> ((serv & $past(prim_mask)) == '0)); // R6
endmodule

bind irq_ctrl_2lvl irqc_checker #(.NUM_SRC(NUM_SRC), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_req   (src_req),
  .src_pend  (src_pend_q),
  .prim_mask (prim_mask_q),
  .serv      (serv_q),
  .cand      (cand),
  .offset    (offset_q),
  .bus_we    (bus_we)
);

// File: tb/sim_irq_ctrl_2lvl.sv
`timescale 1ns/1ps
module sim_irq_ctrl_2lvl;
  localparam int NS   = 16;
  localparam int NSUB = 6;
  localparam int SPG  = 3;
  localparam int SB   = 10;

  localparam logic [2:0] A_SRC = 3'd0, A_PMASK = 3'd1, A_SERV = 3'd2,
                         A_IDX = 3'd3, A_SUB = 3'd4, A_SMASK = 3'd5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   src_req;
  logic [NSUB-1:0] sub_req;
  logic            bus_we;
  logic [2:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_2lvl #(.NUM_SRC(NS), .NUM_SUB(NSUB), .SUB_PER_GRP(SPG), .SUB_BASE(SB)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .sub_req(sub_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse_src(input logic [NS-1:0] v);
    @(negedge clk); src_req = v;
    @(negedge clk); src_req = '0;
  endtask

  task automatic pulse_sub(input logic [NSUB-1:0] v);
    @(negedge clk); sub_req = v;
    @(negedge clk); sub_req = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 src pend", A_SRC, 32'h0);
    rd_chk("R1 sub pend", A_SUB, 32'h0);
    rd_chk("R1 service", A_SERV, 32'h0);
    rd_chk("R1 index", A_IDX, 32'h0);
    rd_chk("R1 prim mask", A_PMASK, 32'h0000_FFFF);
    rd_chk("R1 sub mask", A_SMASK, 32'h0000_003F);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_masked_pend;
    pulse_src(16'h0020);
    rd_chk("R2 masked source pends", A_SRC, 32'h0020);
    idle(3);
    rd_chk("R6 masked not serviced", A_SERV, 32'h0);
    chk("R10 irq low while empty", {31'h0, irq}, 32'h0);
    wr(A_SRC, 32'h0020);
    rd_chk("R3 w1c src", A_SRC, 32'h0);
  endtask

  task automatic t_priority_index;
    wr(A_PMASK, 32'h0);
    pulse_src(16'h0208);
    idle(1);
    rd_chk("R7 lowest wins", A_SERV, 32'h0008);
    rd_chk("R8 index", A_IDX, 32'd3);
    chk("R10 irq high", {31'h0, irq}, 32'h1);
    wr(A_SRC, 32'h0008);
    rd_chk("R9 index kept, service set", A_IDX, 32'd3);
    wr(A_SERV, 32'h0008);
    rd_chk("R9 service cleared", A_SERV, 32'h0);
    rd_chk("R9 index zero after both clears", A_IDX, 32'd0);
    idle(1);
    rd_chk("R7 next winner", A_SERV, 32'h0200);
    rd_chk("R8 index next", A_IDX, 32'd9);
    wr(A_SERV, 32'h0200);
    rd_chk("R9 index kept, pend set", A_IDX, 32'd9);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    idle(1);
    rd_chk("R7 relatch pending", A_SERV, 32'h0200);
    wr(A_SRC, 32'h0200);
    wr(A_SERV, 32'h0200);
    rd_chk("R9 final index zero", A_IDX, 32'd0);
    idle(2);
    rd_chk("R7 nothing left", A_SERV, 32'h0);
  endtask

  task automatic t_w1c_zero;
    wr(A_PMASK, 32'h0040);
    pulse_src(16'h0040);
    rd_chk("R2 bit6 pends", A_SRC, 32'h0040);
    wr(A_SRC, 32'h0000_FFBF);
    rd_chk("R3 zero bits untouched", A_SRC, 32'h0040);
    wr(A_SRC, 32'h0040);
    rd_chk("R3 one clears", A_SRC, 32'h0);
  endtask

  task automatic t_hw_wins;
    @(negedge clk); src_req = 16'h0040;
    wr(A_SRC, 32'h0040);
    rd_chk("R4 set beats clear", A_SRC, 32'h0040);
    @(negedge clk); src_req = '0;
    wr(A_SRC, 32'h0040);
    rd_chk("R4 later clear works", A_SRC, 32'h0);
  endtask

  task automatic t_busy_hold;
    wr(A_PMASK, 32'h0);
    pulse_src(16'h1000);
    idle(1);
    rd_chk("R7 bit12 in service", A_SERV, 32'h1000);
    pulse_src(16'h0001);
    idle(2);
    rd_chk("R7 busy holds", A_SERV, 32'h1000);
    rd_chk("R8 index held", A_IDX, 32'd12);
    rd_chk("R2 both pending", A_SRC, 32'h1001);
    wr(A_SRC, 32'h1000);
    wr(A_SERV, 32'h1000);
    rd_chk("R9 index zero", A_IDX, 32'd0);
    idle(1);
    rd_chk("R7 bit0 next", A_SERV, 32'h0001);
    rd_chk("R8 index 0 in service", A_IDX, 32'd0);
    wr(A_SRC, 32'h0001);
    wr(A_SERV, 32'h0001);
    rd_chk("R3 service cleared", A_SERV, 32'h0);
  endtask

  task automatic t_secondary;
    wr(A_PMASK, 32'h0);
    pulse_sub(6'h10);
    rd_chk("R5 sub pends", A_SUB, 32'h10);
    idle(3);
    rd_chk("R5 masked sub no primary", A_SRC, 32'h0);
    wr(A_SMASK, 32'h2F);
    idle(2);
    rd_chk("R5 group1 sets bit11", A_SRC, 32'h0800);
    rd_chk("R7 bit11 in service", A_SERV, 32'h0800);
    rd_chk("R8 index 11", A_IDX, 32'd11);
    wr(A_SUB, 32'h10);
    rd_chk("R3 sub w1c", A_SUB, 32'h0);
    wr(A_SRC, 32'h0800);
    rd_chk("R5 primary stays clear", A_SRC, 32'h0);
    wr(A_SERV, 32'h0800);
    rd_chk("R9 index zero", A_IDX, 32'd0);
    wr(A_SMASK, 32'h0);
    pulse_sub(6'h04);
    idle(3);
    rd_chk("R5 group0 sets bit10", A_SRC, 32'h0400);
    rd_chk("R7 bit10 in service", A_SERV, 32'h0400);
    pulse_sub(6'h20);
    idle(2);
    rd_chk("R5 both groups", A_SRC, 32'h0C00);
    rd_chk("R7 still bit10", A_SERV, 32'h0400);
    wr(A_SUB, 32'h3F);
    wr(A_SRC, 32'hFFFF);
    wr(A_SERV, 32'hFFFF);
    idle(2);
    rd_chk("R3 all clear", A_SERV, 32'h0);
    chk("R10 irq low end", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_req = '0; sub_req = '0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_pend();
    t_priority_index();
    t_w1c_zero();
    t_hw_wins();
    t_busy_hold();
    t_secondary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule